// File: doc/BRIEF.md
# Clock Reference Priority Selector

This block decides which of four candidate timing references steers a network element's central clock. Two candidates are external building-timing inputs: a primary port and a redundant port. The other two are references recovered from line ports, called ref1 and ref2. Each candidate supplies four things:

- a loss-of-signal flag
- an administrative enable
- a received 4-bit quality-level code
- an optional override code that replaces the received code

A candidate counts as qualified only after it has been healthy for a programmable settling time. A short glitch on loss of signal therefore cannot make the selection bounce.

Priority comes from a three-slot order list that names the external input, ref1 and ref2. The external slot stands for two entries: the primary port first, then the redundant port. Two mode inputs choose the selection rule:

- strict priority, either revertive or non-revertive
- highest quality level, where each external port is judged on its own code and ties go to the higher priority

The block registers the result every cycle. It reports the selected index, a valid flag and the system quality level. For each candidate it also reports qualified and selected status and a reason code. A separate select steers an external timing output, which may only carry ref1 or ref2.

Top module: `clkref_selector`

## Requirements
- R1: Candidate indices are 0 for the primary external port, 1 for the redundant external port, 2 for ref1 and 3 for ref2. `slot_order` holds three 2-bit slot codes, and bits [1:0] are the most important slot. The codes are 0 for the external input, 1 for ref1, 2 for ref2 and 3 for an empty slot. An external slot ranks the primary port just above the redundant port. When a slot code appears twice, its first (most important) position counts. A candidate whose slot is absent from the list is never selected.
- R2: A candidate becomes qualified once its enable is 1 and its loss flag is 0 on `hold_cycles`+1 consecutive rising clock edges. `cand_qual` drops in the same cycle that the candidate is disabled or loses its signal.
- R3: Each candidate has a 3-bit reason code in `cand_reason[3i+2:3i]`, taken from the first condition in this list that applies:
  - 1: disabled
  - 2: loss of signal
  - 3: still settling
  - 4: carrying code 0xF while quality mode is on
  - 0: none of the above, and the candidate is qualified
- R4: A candidate's effective quality code is its override code when the override enable is 1, and its received code otherwise. The rank of an effective code, best first, is 0x2, then 0x4, then 0x8, then 0xB, then every other code equally. Code 0xF disqualifies a candidate only while `ql_mode` is 1.
- R5: With `ql_mode` at 1, the usable candidate with the best rank is selected. When ranks are equal, the higher priority wins.
- R6: With `ql_mode` at 0 and `revert_en` at 1, the usable candidate of highest priority is selected. This includes a higher-priority candidate that has just requalified.
- R7: With `ql_mode` at 0 and `revert_en` at 0, the current selection is kept for as long as it stays usable. When it stops being usable, the usable candidate of highest priority is taken.
- R8: `sel_idx`, `sel_valid` and `sys_ql` are registered. They reflect the inputs present before the last rising edge, and `sys_ql` carries the effective code of the selected candidate. `cand_sel` is one-hot on `sel_idx` while `sel_valid` is 1, and zero otherwise.
- R9: When no candidate is usable, `sel_valid` is 0, `sel_idx` keeps its last value and `sys_ql` reports the holdover code 0x0.
- R10: `tout_sel` is 2 when `tout_pick` is 0 and 3 when `tout_pick` is 1. `tout_ok` equals the qualified status of that candidate.
- R11: During reset, `sel_valid` is 0, `sel_idx` is 0, `sys_ql` is 0x0 and no candidate is qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_los | input | 4 | Loss-of-signal flag per candidate |
| cand_en | input | 4 | Administrative enable per candidate |
| cand_ql_rx | input | 16 | Received quality code, 4 bits per candidate |
| cand_ovr_en | input | 4 | Override enable per candidate |
| cand_ovr_ql | input | 16 | Override quality code, 4 bits per candidate |
| slot_order | input | 6 | Three 2-bit slot codes, most important in bits [1:0] |
| ql_mode | input | 1 | Quality-based selection on |
| revert_en | input | 1 | Revertive mode for priority selection |
| hold_cycles | input | 8 | Settling time before requalification |
| tout_pick | input | 1 | External output source: 0 ref1, 1 ref2 |
| sel_idx | output | 2 | Selected candidate index |
| sel_valid | output | 1 | A candidate is selected |
| sys_ql | output | 4 | System quality code |
| cand_qual | output | 4 | Qualified status per candidate |
| cand_sel | output | 4 | Selected status per candidate |
| cand_reason | output | 12 | Reason code, 3 bits per candidate |
| tout_sel | output | 2 | Candidate index driving the external timing output |
| tout_ok | output | 1 | The external output source is qualified |

## Verification
The assertions assume three things about the inputs:

- Every input changes synchronously with the clock.
- `hold_cycles` stays fixed while a candidate is settling.
- The selected index is judged against usability as it stood at the previous edge.

The stimulus respects all three. It changes inputs only just after a falling edge, programs the settling time once before reset is released, and lets each configuration step sit for at least one full cycle before the registered selection is compared. The scenarios drive loss, disable, override, order and mode changes one at a time, so that each expected index follows from a single requirement.

// File: rtl/clkref_pkg.sv
// Shared constants, types and the quality ranking for the clock reference selector.
// Assumes four candidates in fixed roles: two external ports and two line references.
package clkref_pkg;
    localparam int NCAND  = 4;
    localparam int CIDW   = $clog2(NCAND);
    localparam int QLW    = 4;
    localparam int NSLOT  = 3;
    localparam int SLOTW  = 2;
    localparam int PRIOW  = 3;
    localparam int RANKW  = 3;
    localparam logic [PRIOW-1:0] PRIO_NONE = '1;
    localparam logic [QLW-1:0]   QL_DNU    = 4'hF;

    typedef enum logic [SLOTW-1:0] {
        SLOT_EXT  = 2'd0,
        SLOT_REF1 = 2'd1,
        SLOT_REF2 = 2'd2,
        SLOT_NONE = 2'd3
    } slot_e;

    typedef enum logic [2:0] {
        RSN_OK     = 3'd0,
        RSN_ADMIN  = 3'd1,
        RSN_LOS    = 3'd2,
        RSN_SETTLE = 3'd3,
        RSN_DNU    = 3'd4
    } reason_e;

    // Map a quality code onto a rank where larger is better.
    function automatic logic [RANKW-1:0] ql_rank(input logic [QLW-1:0] code);
        case (code)
            4'h2:    ql_rank = 3'd5;
            4'h4:    ql_rank = 3'd4;
            4'h8:    ql_rank = 3'd3;
            4'hB:    ql_rank = 3'd2;
            4'hF:    ql_rank = 3'd0;
            default: ql_rank = 3'd1;
        endcase
    endfunction
endpackage

// File: rtl/clkref_qual.sv
// One candidate's qualification: settle counter, qualified flag and reason code.
// Assumes hold_cycles is stable while a candidate is settling.
module clkref_qual
    import clkref_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              los,
    input  logic              en,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic [QLW-1:0]    ql_eff,
    input  logic              ql_mode,
    output logic              qual,
    output reason_e           reason
);
    logic [HOLD_W-1:0] cnt;
    logic              done;
    logic              raw_ok;
    logic              dnu;

    // Raw health and the do-not-use condition.
    always_comb begin
        raw_ok = en && !los;
        dnu    = ql_mode && (ql_eff == QL_DNU);
    end

    // Count consecutive healthy edges until the settle time has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!raw_ok) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt >= hold_cycles) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Qualified status and the first reason that applies.
    always_comb begin
        qual = raw_ok && done && !dnu;
        if (!en)        reason = RSN_ADMIN;
        else if (los)   reason = RSN_LOS;
        else if (!done) reason = RSN_SETTLE;
        else if (dnu)   reason = RSN_DNU;
        else            reason = RSN_OK;
    end

    p_drop_on_loss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_ok |=> !done);
    p_settle_healthy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(raw_ok));
endmodule

// File: rtl/clkref_rank.sv
// Expands the three-slot order list into a priority rank per candidate.
// Smaller rank wins; PRIO_NONE marks a candidate whose slot is not listed.
module clkref_rank
    import clkref_pkg::*;
(
    input  logic [NSLOT*SLOTW-1:0]        slot_order,
    output logic [NCAND-1:0][PRIOW-1:0]   prio
);
    // Most important position holding a given slot code, or NSLOT when absent.
    function automatic logic [1:0] first_pos(input logic [NSLOT*SLOTW-1:0] ord,
                                             input slot_e s);
        first_pos = 2'(NSLOT);
        for (int p = NSLOT - 1; p >= 0; p--) begin
            if (ord[p*SLOTW +: SLOTW] == s) first_pos = 2'(p);
        end
    endfunction

    logic [1:0] pos_ext, pos_r1, pos_r2;

    // Two ranks per position keep the primary and redundant ports adjacent.
    always_comb begin
        pos_ext = first_pos(slot_order, SLOT_EXT);
        pos_r1  = first_pos(slot_order, SLOT_REF1);
        pos_r2  = first_pos(slot_order, SLOT_REF2);
        prio[0] = (pos_ext == 2'(NSLOT)) ? PRIO_NONE : {pos_ext, 1'b0};
        prio[1] = (pos_ext == 2'(NSLOT)) ? PRIO_NONE : {pos_ext, 1'b1};
        prio[2] = (pos_r1  == 2'(NSLOT)) ? PRIO_NONE : {pos_r1,  1'b0};
        prio[3] = (pos_r2  == 2'(NSLOT)) ? PRIO_NONE : {pos_r2,  1'b0};
    end
endmodule

// File: rtl/clkref_choose.sv
// Selection rules and the registered selection and system quality.
// Assumes usable already combines qualification with presence in the order list.
module clkref_choose
    import clkref_pkg::*;
#(
    parameter logic [QLW-1:0] QL_HOLD = 4'h0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCAND-1:0]            usable,
    input  logic [NCAND-1:0][PRIOW-1:0] prio,
    input  logic [NCAND-1:0][QLW-1:0]   ql_eff,
    input  logic                        ql_mode,
    input  logic                        revert_en,
    output logic [CIDW-1:0]             cur_idx,
    output logic                        cur_valid,
    output logic [QLW-1:0]              sys_ql
);
    logic [CIDW-1:0] best_p, best_q, nxt_idx;
    logic            any_ok;
    logic [NCAND-1:0][RANKW-1:0] qlr;

    // Best candidate by priority and best candidate by quality rank.
    always_comb begin
        logic fp, fq;
        fp = 1'b0;
        fq = 1'b0;
        best_p = '0;
        best_q = '0;
        for (int i = 0; i < NCAND; i++) begin
            qlr[i] = ql_rank(ql_eff[i]);
        end
        for (int i = 0; i < NCAND; i++) begin
            if (usable[i] && (!fp || prio[i] < prio[best_p])) begin
                best_p = CIDW'(i);
                fp = 1'b1;
            end
            if (usable[i] && (!fq || qlr[i] > qlr[best_q] ||
                (qlr[i] == qlr[best_q] && prio[i] < prio[best_q]))) begin
                best_q = CIDW'(i);
                fq = 1'b1;
            end
        end
    end

    // Mode-dependent choice of the next selection.
    always_comb begin
        any_ok = |usable;
        if (!any_ok)                                       nxt_idx = cur_idx;
        else if (ql_mode)                                  nxt_idx = best_q;
        else if (!revert_en && cur_valid && usable[cur_idx]) nxt_idx = cur_idx;
        else                                               nxt_idx = best_p;
    end

    // Register the selection and the system quality in one step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx   <= '0;
            cur_valid <= 1'b0;
            sys_ql    <= QL_HOLD;
        end else begin
            cur_idx   <= nxt_idx;
            cur_valid <= any_ok;
            sys_ql    <= any_ok ? ql_eff[nxt_idx] : QL_HOLD;
        end
    end

    logic [NCAND-1:0] usable_d;
    // Delayed usability for checking the registered selection.
    always_ff @(posedge clk) usable_d <= usable;

    p_sel_usable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cur_valid |-> usable_d[cur_idx]);
    p_valid_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|usable) |=> cur_valid);
    p_none_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|usable) |=> !cur_valid);
    p_holdover_ql_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_valid |-> sys_ql == QL_HOLD);
    p_nonrev_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ql_mode && !revert_en && cur_valid && usable[cur_idx]) |=>
        (cur_idx == $past(cur_idx)));
endmodule

// File: rtl/clkref_selector.sv
// Top of the clock reference selector: per-candidate qualification, order
// expansion, selection and the external timing output select.
// Assumes all inputs are synchronous to clk.
module clkref_selector
    import clkref_pkg::*;
#(
    parameter int              HOLD_W  = 8,
    parameter logic [QLW-1:0]  QL_HOLD = 4'h0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCAND-1:0]        cand_los,
    input  logic [NCAND-1:0]        cand_en,
    input  logic [NCAND*QLW-1:0]    cand_ql_rx,
    input  logic [NCAND-1:0]        cand_ovr_en,
    input  logic [NCAND*QLW-1:0]    cand_ovr_ql,
    input  logic [NSLOT*SLOTW-1:0]  slot_order,
    input  logic                    ql_mode,
    input  logic                    revert_en,
    input  logic [HOLD_W-1:0]       hold_cycles,
    input  logic                    tout_pick,
    output logic [CIDW-1:0]         sel_idx,
    output logic                    sel_valid,
    output logic [QLW-1:0]          sys_ql,
    output logic [NCAND-1:0]        cand_qual,
    output logic [NCAND-1:0]        cand_sel,
    output logic [NCAND*3-1:0]      cand_reason,
    output logic [CIDW-1:0]         tout_sel,
    output logic                    tout_ok
);
    logic [NCAND-1:0][QLW-1:0]   ql_eff;
    logic [NCAND-1:0][PRIOW-1:0] prio;
    logic [NCAND-1:0]            usable;

    generate
        for (genvar g = 0; g < NCAND; g++) begin : g_cand
            reason_e rsn;

            // Override replaces the received quality code.
            always_comb begin
                ql_eff[g] = cand_ovr_en[g] ? cand_ovr_ql[g*QLW +: QLW]
                                           : cand_ql_rx[g*QLW +: QLW];
            end

            clkref_qual #(.HOLD_W(HOLD_W)) u_qual (
                .clk         (clk),
                .rst_n       (rst_n),
                .los         (cand_los[g]),
                .en          (cand_en[g]),
                .hold_cycles (hold_cycles),
                .ql_eff      (ql_eff[g]),
                .ql_mode     (ql_mode),
                .qual        (cand_qual[g]),
                .reason      (rsn)
            );

            // Publish the reason and combine qualification with order presence.
            always_comb begin
                cand_reason[g*3 +: 3] = rsn;
                usable[g] = cand_qual[g] && (prio[g] != PRIO_NONE);
            end
        end
    endgenerate

    clkref_rank u_rank (
        .slot_order (slot_order),
        .prio       (prio)
    );

    clkref_choose #(.QL_HOLD(QL_HOLD)) u_choose (
        .clk       (clk),
        .rst_n     (rst_n),
        .usable    (usable),
        .prio      (prio),
        .ql_eff    (ql_eff),
        .ql_mode   (ql_mode),
        .revert_en (revert_en),
        .cur_idx   (sel_idx),
        .cur_valid (sel_valid),
        .sys_ql    (sys_ql)
    );

    // Per-candidate selected flags and the line-only external output select.
    always_comb begin
        cand_sel = sel_valid ? (NCAND'(1) << sel_idx) : '0;
        tout_sel = {1'b1, tout_pick};
        tout_ok  = cand_qual[tout_sel];
    end
endmodule

// File: tb/clkref_selector_tb.sv
module clkref_selector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cand_los = 4'h0, cand_en = 4'hF, cand_ovr_en = 4'h0;
    logic [15:0] cand_ql_rx = 16'h4444, cand_ovr_ql = 16'h0000;
    logic [5:0]  slot_order = {2'd2, 2'd1, 2'd0};
    logic        ql_mode = 1'b0, revert_en = 1'b1, tout_pick = 1'b0;
    logic [7:0]  hold_cycles = 8'd3;
    logic [1:0]  sel_idx, tout_sel;
    logic        sel_valid, tout_ok;
    logic [3:0]  sys_ql, cand_qual, cand_sel;
    logic [11:0] cand_reason;

    int checks = 0;
    int errors = 0;

    bit         sb_v[$];
    logic [1:0] sb_i[$];
    logic [3:0] sb_q[$];
    string      sb_t[$];

    always #4 clk = ~clk;

    clkref_selector u_dut (
        .clk(clk), .rst_n(rst_n), .cand_los(cand_los), .cand_en(cand_en),
        .cand_ql_rx(cand_ql_rx), .cand_ovr_en(cand_ovr_en), .cand_ovr_ql(cand_ovr_ql),
        .slot_order(slot_order), .ql_mode(ql_mode), .revert_en(revert_en),
        .hold_cycles(hold_cycles), .tout_pick(tout_pick), .sel_idx(sel_idx),
        .sel_valid(sel_valid), .sys_ql(sys_ql), .cand_qual(cand_qual),
        .cand_sel(cand_sel), .cand_reason(cand_reason), .tout_sel(tout_sel),
        .tout_ok(tout_ok)
    );

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    // Driver side: queue the registered result due after the next edge.
    task automatic expect_sel(input bit v, input logic [1:0] i,
                              input logic [3:0] q, input string tag);
        sb_v.push_back(v);
        sb_i.push_back(i);
        sb_q.push_back(q);
        sb_t.push_back(tag);
        tick(1);
    endtask

    task automatic check_eq(input logic [31:0] act, input logic [31:0] exp,
                            input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor side: pop and compare the registered selection.
    always @(negedge clk) begin
        if (sb_v.size() > 0) begin
            bit v;
            logic [1:0] i;
            logic [3:0] q;
            string t;
            v = sb_v.pop_front();
            i = sb_i.pop_front();
            q = sb_q.pop_front();
            t = sb_t.pop_front();
            checks++;
            if (sel_valid !== v || sel_idx !== i || sys_ql !== q) begin
                errors++;
                $display("FAIL %s actual v=%0d idx=%0d ql=%h expected v=%0d idx=%0d ql=%h",
                         t, sel_valid, sel_idx, sys_ql, v, i, q);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        check_eq(sel_valid, 0, "R11 valid");
        check_eq(sel_idx, 0, "R11 idx");
        check_eq(sys_ql, 4'h0, "R11 ql");
        check_eq(cand_qual, 0, "R11 qual");

        rst_n = 1'b1;
        #1;
        check_eq(cand_reason[2:0], 3, "R3 settling");
        tick(5);
        expect_sel(1, 0, 4'h4, "R6 primary first");
        check_eq(cand_sel, 4'b0001, "R8 one-hot");

        // Loss on the primary: the redundant port of the same slot takes over.
        cand_los[0] = 1'b1;
        #1;
        check_eq(cand_qual[0], 0, "R2 immediate drop");
        check_eq(cand_reason[2:0], 2, "R3 los");
        expect_sel(1, 1, 4'h4, "R1 redundant next");
        cand_los[0] = 1'b0;
        for (int k = 0; k < 4; k++) expect_sel(1, 1, 4'h4, "R2 settling");
        expect_sel(1, 0, 4'h4, "R6 revert after requalify");

        // Non-revertive behaviour.
        revert_en = 1'b0;
        cand_los[0] = 1'b1;
        expect_sel(1, 1, 4'h4, "R7 switch on loss");
        cand_los[0] = 1'b0;
        tick(8);
        expect_sel(1, 1, 4'h4, "R7 keep current");
        cand_en[1] = 1'b0;
        #1;
        check_eq(cand_reason[5:3], 1, "R3 disabled");
        expect_sel(1, 0, 4'h4, "R7 fall back to priority");
        cand_en[1] = 1'b1;
        revert_en = 1'b1;
        tick(6);

        // Order list handling.
        slot_order = {2'd0, 2'd1, 2'd2};
        expect_sel(1, 3, 4'h4, "R1 ref2 first");
        slot_order = {2'd3, 2'd3, 2'd1};
        expect_sel(1, 2, 4'h4, "R1 only ref1 listed");
        slot_order = {2'd2, 2'd2, 2'd3};
        expect_sel(1, 3, 4'h4, "R1 duplicate slot");
        slot_order = 6'h3F;
        expect_sel(0, 3, 4'h0, "R9 nothing listed");
        slot_order = {2'd2, 2'd1, 2'd0};

        // External output select.
        tout_pick = 1'b0;
        #1;
        check_eq(tout_sel, 2, "R10 ref1 sel");
        check_eq(tout_ok, 1, "R10 ref1 ok");
        tout_pick = 1'b1;
        cand_en[3] = 1'b0;
        #1;
        check_eq(tout_sel, 3, "R10 ref2 sel");
        check_eq(tout_ok, 0, "R10 ref2 not ok");
        expect_sel(1, 0, 4'h4, "R6 order restored");
        cand_en[3] = 1'b1;
        tick(6);

        // Quality-based selection.
        ql_mode = 1'b1;
        cand_ql_rx = 16'h2244;
        expect_sel(1, 2, 4'h2, "R5 best quality, priority tie");
        cand_ovr_en[1] = 1'b1;
        cand_ovr_ql = 16'h0020;
        expect_sel(1, 1, 4'h2, "R4 override wins tie");
        cand_ovr_ql = 16'h00F0;
        #1;
        check_eq(cand_reason[5:3], 4, "R3 do-not-use");
        check_eq(cand_qual[1], 0, "R4 do-not-use disqualifies");
        expect_sel(1, 2, 4'h2, "R5 skip do-not-use");
        cand_ql_rx = 16'h2F44;
        expect_sel(1, 3, 4'h2, "R5 ref2 best");
        ql_mode = 1'b0;
        expect_sel(1, 0, 4'h4, "R4 do-not-use ignored in priority mode");
        cand_ovr_en = 4'h0;
        ql_mode = 1'b1;
        cand_ql_rx = 16'h50B8;
        expect_sel(1, 0, 4'h8, "R4 rank 0x8 over 0xB");
        cand_los[0] = 1'b1;
        expect_sel(1, 1, 4'hB, "R4 rank 0xB over others");

        cand_los = 4'hF;
        expect_sel(0, 1, 4'h0, "R9 holdover");
        tick(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule